// File: doc/BRIEF.md
# Trigger-Driven Acquisition Sequencer

This block runs one acquisition cycle of a multichannel front end at board level. In idle it waits for a first-level trigger or a clear. A trigger starts all converters in parallel, for example one for the held energy value and one for the timing value. It gates the converter clock on and waits until every converter has reported completion. It then sends a one-cycle start to the downstream readout engine and resets the peak-hold stage before it returns to idle. A clear does no conversion and only resets the hold stage.

The hold-reset pulse length and the conversion timeout are parameters. A conversion that does not finish within the timeout is abandoned and the hold stage is reset. A sticky error flag records the event until the next reset. No trigger is accepted while the readout engine reports busy. The busy output tells the trigger source whether the sequencer can take a trigger.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it is released, all outputs are 0.
- R2: A trigger sampled in idle while `rdo_busy_i` is low raises `conv_start_o` for exactly the next cycle. That is the first cycle of conversion.
- R3: `conv_clk_en_o` is high only during conversion. It is never high together with `hold_rst_o` or `rdo_start_o`.
- R4: Conversion ends only after every bit of `conv_done_i` has been seen high at least once since it began. The flags may arrive as single-cycle pulses at different times. `rdo_start_o` rises in the cycle after the last missing flag is sampled.
- R5: `rdo_start_o` is a single-cycle pulse. `hold_rst_o` starts in the cycle directly after it.
- R6: `hold_rst_o` stays high for exactly HOLD_CYCLES cycles. The sequencer is idle in the cycle after that.
- R7: A clear sampled in idle with no accepted trigger raises `hold_rst_o` in the next cycle. It causes no `conv_start_o`, `conv_clk_en_o` or `rdo_start_o`.
- R8: When a trigger and a clear are sampled in the same idle cycle and the trigger is accepted, conversion starts. The clear has no effect.
- R9: While `rdo_busy_i` is high a trigger is ignored, and a clear in the same cycle still acts. `busy_o` is high whenever `rdo_busy_i` is high or the sequencer is not idle.
- R10: If the flags are not complete within TIMEOUT_CYCLES conversion cycles, conversion stops after cycle TIMEOUT_CYCLES. `hold_rst_o` follows with no `rdo_start_o`, and `timeout_err_o` goes high and stays high until reset.
- R11: Triggers, clears and done flags that arrive outside idle (or, for done flags, outside conversion) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | First-level trigger |
| clr_i | input | 1 | Clear (discard held event) |
| conv_done_i | input | N_CONV | Per-converter completion flags |
| rdo_busy_i | input | 1 | Readout engine still sending |
| conv_start_o | output | 1 | Start pulse for all converters |
| conv_clk_en_o | output | 1 | Converter clock gate enable |
| hold_rst_o | output | 1 | Peak-hold reset pulse |
| rdo_start_o | output | 1 | Readout start pulse |
| busy_o | output | 1 | Trigger cannot be accepted |
| timeout_err_o | output | 1 | Sticky conversion-timeout flag |

## Verification
The assertions check the following on every cycle: the start and readout pulses each last one cycle, the converter clock enable never overlaps the hold or readout phases, a busy readout engine blocks conversion, the trigger wins over a clear, and the timeout flag stays set. The bench sweeps the arrival cycles of both done flags across and beyond the timeout window. Only that sweep shows that the end of conversion follows the last flag exactly, that hold-reset length and timeout cycle counts are exact, and that stray stimulus outside idle is ignored.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_LAUNCH  = 2'd2,
        ST_HOLD    = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic trig;
        logic clr;
        logic rdo_busy;
    } seq_req_t;

    // width of a down-counter that must hold n-1
    function automatic int cnt_width(input int n);
        return (n < 3) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/acq_seq_timer.sv
module acq_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // counter never moves upward except on a load
    p_timer_down_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/acq_seq_done_track.sv
module acq_seq_done_track #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         capture,
    input  logic [N-1:0] done_i,
    output logic         all_done
);
    logic [N-1:0] seen_q;
    logic [N-1:0] seen_now;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clear)
                seen_q[g] <= 1'b0;
            else if (capture && done_i[g])
                seen_q[g] <= 1'b1;
        end
        assign seen_now[g] = seen_q[g] | done_i[g];

        // a recorded flag is kept until the next conversion starts
        p_seen_keep_r4: assert property (@(posedge clk) disable iff (rst)
            seen_q[g] && !clear |=> seen_q[g]);
    end

    assign all_done = capture && (&seen_now);

endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
    import acq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_req_t   req,
    input  logic       all_done,
    input  logic       hold_exp,
    input  logic       tmo_exp,
    output seq_state_e state_q,
    output logic       enter_conv,
    output logic       enter_hold,
    output logic       conv_start_q,
    output logic       err_q
);
    seq_state_e state_d;
    logic       timed_out;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req.trig && !req.rdo_busy) state_d = ST_CONVERT;
                else if (req.clr)              state_d = ST_HOLD;
            end
            ST_CONVERT: begin
                if (all_done)     state_d = ST_LAUNCH;
                else if (tmo_exp) state_d = ST_HOLD;
            end
            ST_LAUNCH: state_d = ST_HOLD;
            ST_HOLD: begin
                if (hold_exp) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign enter_conv = (state_q == ST_IDLE) && (state_d == ST_CONVERT);
    assign enter_hold = (state_q != ST_HOLD) && (state_d == ST_HOLD);
    assign timed_out  = (state_q == ST_CONVERT) && !all_done && tmo_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            conv_start_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            state_q      <= state_d;
            conv_start_q <= enter_conv;
            err_q        <= err_q | timed_out;
        end
    end

    p_start_one_r2: assert property (@(posedge clk) disable iff (rst)
        conv_start_q |=> !conv_start_q);
    p_start_in_conv_r2: assert property (@(posedge clk) disable iff (rst)
        conv_start_q |-> state_q == ST_CONVERT);
    p_trig_wins_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE && req.trig && req.clr && !req.rdo_busy |=> state_q == ST_CONVERT);
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE && req.rdo_busy |=> state_q != ST_CONVERT);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    p_launch_one_r5: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_LAUNCH |=> state_q == ST_HOLD);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int N_CONV         = 2,
    parameter int HOLD_CYCLES    = 4,
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              clr_i,
    input  logic [N_CONV-1:0] conv_done_i,
    input  logic              rdo_busy_i,
    output logic              conv_start_o,
    output logic              conv_clk_en_o,
    output logic              hold_rst_o,
    output logic              rdo_start_o,
    output logic              busy_o,
    output logic              timeout_err_o
);
    localparam int HOLD_W = cnt_width(HOLD_CYCLES);
    localparam int TMO_W  = cnt_width(TIMEOUT_CYCLES);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES - 1);
    localparam logic [TMO_W-1:0]  TMO_LOAD  = TMO_W'(TIMEOUT_CYCLES - 1);

    seq_req_t   req;
    seq_state_e state;
    logic       enter_conv, enter_hold;
    logic       all_done, hold_exp, tmo_exp;
    logic       in_conv, in_hold;

    assign req.trig     = trig_i;
    assign req.clr      = clr_i;
    assign req.rdo_busy = rdo_busy_i;
    assign in_conv      = (state == ST_CONVERT);
    assign in_hold      = (state == ST_HOLD);

    acq_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .all_done     (all_done),
        .hold_exp     (hold_exp),
        .tmo_exp      (tmo_exp),
        .state_q      (state),
        .enter_conv   (enter_conv),
        .enter_hold   (enter_hold),
        .conv_start_q (conv_start_o),
        .err_q        (timeout_err_o)
    );

    acq_seq_done_track #(.N(N_CONV)) u_done (
        .clk      (clk),
        .rst      (rst),
        .clear    (enter_conv),
        .capture  (in_conv),
        .done_i   (conv_done_i),
        .all_done (all_done)
    );

    acq_seq_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (enter_hold),
        .load_val (HOLD_LOAD),
        .run      (in_hold),
        .expired  (hold_exp)
    );

    acq_seq_timer #(.W(TMO_W)) u_tmo_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (enter_conv),
        .load_val (TMO_LOAD),
        .run      (in_conv),
        .expired  (tmo_exp)
    );

    assign conv_clk_en_o = in_conv;
    assign hold_rst_o    = in_hold;
    assign rdo_start_o   = (state == ST_LAUNCH);
    assign busy_o        = (state != ST_IDLE) || rdo_busy_i;

    p_clk_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        conv_clk_en_o |-> !hold_rst_o && !rdo_start_o);
    p_rdo_then_hold_r5: assert property (@(posedge clk) disable iff (rst)
        rdo_start_o |=> !rdo_start_o && hold_rst_o);
    p_clr_no_conv_r7: assert property (@(posedge clk) disable iff (rst)
        !busy_o && clr_i && !trig_i |=> hold_rst_o && !conv_clk_en_o);

endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb;
    localparam int NC = 2;
    localparam int H  = 3;
    localparam int T  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0, clr = 1'b0, rbusy = 1'b0;
    logic [NC-1:0] done = '0;
    logic          cstart, cken, hrst, rstart, busy, err;
    int            checks = 0, errors = 0;
    logic          exp_err = 1'b0;

    always #10 clk = ~clk;

    acq_sequencer #(.N_CONV(NC), .HOLD_CYCLES(H), .TIMEOUT_CYCLES(T)) u_dut (
        .clk(clk), .rst(rst), .trig_i(trig), .clr_i(clr), .conv_done_i(done),
        .rdo_busy_i(rbusy), .conv_start_o(cstart), .conv_clk_en_o(cken),
        .hold_rst_o(hrst), .rdo_start_o(rstart), .busy_o(busy), .timeout_err_o(err)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "conv_start", cstart, 1'b0);
        check(req, "clk_en", cken, 1'b0);
        check(req, "hold_rst", hrst, 1'b0);
        check(req, "rdo_start", rstart, 1'b0);
        check(req, "busy", busy, rbusy);
    endtask

    // one triggered acquisition; done bit i pulses in conversion cycle di
    task automatic run_acq(input int d0, input int d1, input bit with_clr, input bit poke);
        int m, e, last;
        bit ok;
        m    = (d0 > d1) ? d0 : d1;
        ok   = (m <= T - 1);
        e    = ok ? m : T - 1;
        last = e + (ok ? 1 : 0) + H;
        if (!ok) exp_err = 1'b1;
        @(negedge clk);
        trig = 1'b1;
        clr  = with_clr;
        for (int k = 0; k <= last + 1; k++) begin
            @(negedge clk);
            trig = 1'b0;
            clr  = 1'b0;
            check("R2", "conv_start", cstart, k == 0);
            check("R3", "clk_en", cken, k <= e);
            check("R4", "rdo_start", rstart, ok && k == e + 1);
            check(ok ? "R6" : "R10", "hold_rst", hrst, (k > e + (ok ? 1 : 0)) && k <= last);
            check("R9", "busy", busy, k <= last);
            done[0] = (k == d0);
            done[1] = (k == d1);
            if (poke && k == 1) begin   // R11: stray trigger and clear mid-cycle
                trig = 1'b1;
                clr  = 1'b1;
            end
        end
        done = '0;
        check("R10", "timeout_err", err, exp_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        check("R1", "timeout_err", err, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        check("R1", "timeout_err", err, 1'b0);

        // R7: clear alone
        clr = 1'b1;
        for (int k = 0; k <= H; k++) begin
            @(negedge clk);
            clr = 1'b0;
            check("R7", "hold_rst", hrst, k < H);
            check("R7", "clk_en", cken, 1'b0);
            check("R7", "conv_start", cstart, 1'b0);
            check("R7", "rdo_start", rstart, 1'b0);
        end

        // R8: trigger and clear together
        run_acq(1, 2, 1'b1, 1'b0);

        // R9: readout engine busy blocks triggers, clear still acts
        rbusy = 1'b1;
        trig  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9", "busy", busy, 1'b1);
            check("R9", "conv_start", cstart, 1'b0);
            check("R9", "clk_en", cken, 1'b0);
        end
        clr = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        clr  = 1'b0;
        check("R9", "hold_rst after clear", hrst, 1'b1);
        check("R9", "clk_en", cken, 1'b0);
        repeat (H) @(negedge clk);
        check("R9", "hold_rst done", hrst, 1'b0);
        rbusy = 1'b0;
        @(negedge clk);
        check("R9", "busy released", busy, 1'b0);

        // R4, R10, R11: sweep arrival of both done flags
        for (int a = 0; a < T + 2; a++)
            for (int b = 0; b < T + 2; b++)
                run_acq(a, b, 1'b0, ((a + b) % 3) == 0);

        // R10: sticky through a good cycle, cleared only by reset (R1)
        run_acq(0, 0, 1'b0, 1'b0);
        check("R10", "sticky", err, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "timeout_err after reset", err, 1'b0);
        check_idle("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule